// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block moves one byte at a time over a two-wire synchronous link. It does not transmit and receive at the same time. A free-running twelve-slot timer sets the rhythm. Each slot is one clock, and the twelve slots form six states of two phases each. One data bit moves per machine cycle, so the bit rate is the clock frequency divided by twelve.

On transmit, the block drives the data pin and also supplies the shift clock. On receive, it samples the data pin while it still drives the shift clock. Completion in both directions is detected by a marker bit that travels through the shift register, not by a bit counter.

Transmit words arrive on a valid/ready handshake. `tx_ready` is high only in the last slot of a machine cycle, and only while the port is idle. A producer may hold `tx_valid` and `tx_data` for as long as it likes, and nothing is taken until both signals are high at the same rising edge. Reception is armed by the level of `rx_en` while the receive-done flag is clear. Each direction reports completion through a sticky flag, and each flag has its own clear input.

Top module: `ssp_serial_port`

## Requirements
- R1: While reset is held and afterwards whenever no transmission is shifting: `sd_oe` is 0, `sd_out` is 1 and `shift_clk` is 1. Reset also clears `tx_done`, `rx_done` and `rx_data`, and leaves `tx_ready` low.
- R2: Slots are numbered 0 to 11 from reset. Slot 0 is held during reset, and the count advances by one at every edge after release. `tx_ready` is high only during slot 11, and only when neither direction is busy. A word is accepted at the edge where `tx_valid` and `tx_ready` are both high.
- R3: `sd_oe` rises at the 12th edge after acceptance. Bit i (LSB first) is on `sd_out` from edge 12(i+1) to edge 12(i+2) after acceptance.
- R4: `tx_done` sets at the 108th edge after acceptance, which is the same edge at which `sd_oe` falls.
- R5: While transmit data is shifting, `shift_clk` is low in slots 4 to 9 (states 3 to 5) and high in slots 10, 11 and 0 to 3.
- R6: Reception starts at a slot-11 edge where all of these hold: `rx_en` is 1, `rx_done` is 0, both directions are idle and no word is accepted. Reception becomes active one edge later, and while it is active `shift_clk` follows the slot pattern of R5.
- R7: `sd_in` is sampled at slot-9 edges. Counting from the start edge, bit i is the value sampled at edge 10+12i, and it lands in `rx_data[i]`.
- R8: `rx_done` sets and `rx_data` updates at the 96th edge after the start edge. At every other edge `rx_data` holds its value.
- R9: While a transmission is pending or shifting, `tx_ready` stays low. A `tx_valid` in that time is not taken, and the serial output in progress is not changed.
- R10: Each flag stays set until its clear input is high at an edge. A set and a clear at the same edge leave the flag set. While `rx_done` is 1, no reception starts.
- R11: While a reception is armed or active, `tx_ready` stays low, and no reception starts while a transmission is busy. If both directions could start at the same slot-11 edge, the transmit word is taken and reception begins at a later slot-11 edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Port can take a transmit word this edge |
| tx_data | input | DATA_W | Transmit word |
| rx_en | input | 1 | Level that arms reception |
| rx_data | output | DATA_W | Last received word, bit 0 received first |
| tx_done | output | 1 | Sticky transmit-complete flag |
| tx_done_clr | input | 1 | Clears `tx_done` |
| rx_done | output | 1 | Sticky receive-complete flag |
| rx_done_clr | input | 1 | Clears `rx_done` |
| sd_out | output | 1 | Serial data driven onto the data pin |
| sd_oe | output | 1 | Output enable for the data pin |
| sd_in | input | 1 | Serial data read from the data pin |
| shift_clk | output | 1 | Shift clock for the link partner |

## Verification
The bench builds the port with the default eight-bit word. With that width the transmit marker passes through every position of the nine-bit register, and the receive zero walks the full eight-bit register. The bench compares a counter-based model against every output on every clock. Its stimulus reaches a write offered during a busy transfer, a clear that lands on the completion edge, a blocked re-arm while the receive flag is set, and a transmit and a receive contending for the same slot-11 edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int STATES = 6;
  localparam int PHASES = 2;
  localparam int SLOTS  = STATES * PHASES;
  localparam int SLOT_W = $clog2(SLOTS);

  function automatic int slot_of(input int st, input int ph);
    return (st - 1) * PHASES + (ph - 1);
  endfunction

  // shift edge, sample edge, and the low window of the shift clock
  localparam int SLOT_SHIFT     = slot_of(6, 2);
  localparam int SLOT_SAMPLE    = slot_of(5, 2);
  localparam int SLOT_LOW_FIRST = slot_of(3, 1);
  localparam int SLOT_LOW_LAST  = slot_of(5, 2);

  typedef logic [SLOT_W-1:0] slot_t;
  typedef enum logic [1:0] {TX_IDLE, TX_LOAD, TX_SHIFT} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_ARM, RX_SHIFT} rx_state_e;
endpackage

// File: rtl/ssp_slot_timer.sv
module ssp_slot_timer
  import ssp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic shift_stb,
  output logic sample_stb,
  output logic clk_low
);
  slot_t slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          slot_q <= '0;
    else if (slot_q == slot_t'(SLOTS-1)) slot_q <= '0;
    else                                 slot_q <= slot_q + slot_t'(1);
  end

  assign shift_stb  = (slot_q == slot_t'(SLOT_SHIFT));
  assign sample_stb = (slot_q == slot_t'(SLOT_SAMPLE));
  assign clk_low    = (slot_q >= slot_t'(SLOT_LOW_FIRST)) &&
                      (slot_q <= slot_t'(SLOT_LOW_LAST));
endmodule

// File: rtl/ssp_tx_engine.sv
module ssp_tx_engine
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_stb,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              busy,
  output logic              sending,
  output logic              bit_out,
  output logic              finish
);
  localparam int SR_W = DATA_W + 1;
  localparam logic [DATA_W-1:0] MARK_AT_END = {{(DATA_W-1){1'b0}}, 1'b1};

  tx_state_e        st_q;
  logic [SR_W-1:0]  sr_q;
  logic             mark_next;

  // marker sits just above the last data bit, all higher bits zero
  assign mark_next = (sr_q[SR_W-1:1] == MARK_AT_END);
  assign finish    = (st_q == TX_SHIFT) && shift_stb && mark_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TX_IDLE;
      sr_q <= '0;
    end else begin
      case (st_q)
        TX_IDLE:  if (load) begin
                    sr_q <= {1'b1, load_data};
                    st_q <= TX_LOAD;
                  end
        TX_LOAD:  if (shift_stb) st_q <= TX_SHIFT;
        TX_SHIFT: if (shift_stb) begin
                    sr_q <= {1'b0, sr_q[SR_W-1:1]};
                    if (mark_next) st_q <= TX_IDLE;
                  end
        default:  st_q <= TX_IDLE;
      endcase
    end
  end

  assign busy    = (st_q != TX_IDLE);
  assign sending = (st_q == TX_SHIFT);
  assign bit_out = sending ? sr_q[0] : 1'b1;
endmodule

// File: rtl/ssp_rx_engine.sv
module ssp_rx_engine
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_stb,
  input  logic              sample_stb,
  input  logic              start,
  input  logic              bit_in,
  output logic              busy,
  output logic              running,
  output logic              finish,
  output logic [DATA_W-1:0] word
);
  localparam logic [DATA_W-1:0] ARM_PATTERN = {{(DATA_W-1){1'b1}}, 1'b0};

  rx_state_e         st_q;
  logic [DATA_W-1:0] sr_q;
  logic [DATA_W-1:0] word_q;
  logic              samp_q;
  logic [DATA_W-1:0] sr_next;
  logic [DATA_W-1:0] sr_flip;

  assign sr_next = {sr_q[DATA_W-2:0], samp_q};

  // first bit received ends up at the top of the register: mirror it
  for (genvar g = 0; g < DATA_W; g++) begin : g_flip
    assign sr_flip[g] = sr_next[DATA_W-1-g];
  end

  assign finish = (st_q == RX_SHIFT) && shift_stb && !sr_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      sr_q   <= '1;
      word_q <= '0;
      samp_q <= 1'b1;
    end else begin
      if (sample_stb && st_q == RX_SHIFT) samp_q <= bit_in;
      case (st_q)
        RX_IDLE:  if (start) begin
                    sr_q <= ARM_PATTERN;
                    st_q <= RX_ARM;
                  end
        RX_ARM:   st_q <= RX_SHIFT;
        RX_SHIFT: if (shift_stb) begin
                    sr_q <= sr_next;
                    if (!sr_q[DATA_W-1]) begin
                      word_q <= sr_flip;
                      st_q   <= RX_IDLE;
                    end
                  end
        default:  st_q <= RX_IDLE;
      endcase
    end
  end

  assign busy    = (st_q != RX_IDLE);
  assign running = (st_q == RX_SHIFT);
  assign word    = word_q;
endmodule

// File: rtl/ssp_flag.sv
module ssp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/ssp_serial_port.sv
module ssp_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              tx_done,
  input  logic              tx_done_clr,
  output logic              rx_done,
  input  logic              rx_done_clr,
  output logic              sd_out,
  output logic              sd_oe,
  input  logic              sd_in,
  output logic              shift_clk
);
  localparam int N_FLAGS = 2;

  logic shift_stb, sample_stb, clk_low;
  logic tx_busy, tx_sending, tx_bit, tx_finish;
  logic rx_busy, rx_running, rx_finish;
  logic accept, rx_start;
  logic [N_FLAGS-1:0] flag_set, flag_clr, flag_q;

  ssp_slot_timer u_timer (
    .clk(clk), .rst_n(rst_n),
    .shift_stb(shift_stb), .sample_stb(sample_stb), .clk_low(clk_low)
  );

  assign tx_ready = shift_stb && !tx_busy && !rx_busy;
  assign accept   = tx_valid && tx_ready;
  assign rx_start = shift_stb && rx_en && !rx_done && !tx_busy && !rx_busy && !accept;

  ssp_tx_engine #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .shift_stb(shift_stb),
    .load(accept), .load_data(tx_data),
    .busy(tx_busy), .sending(tx_sending), .bit_out(tx_bit), .finish(tx_finish)
  );

  ssp_rx_engine #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .shift_stb(shift_stb), .sample_stb(sample_stb),
    .start(rx_start), .bit_in(sd_in),
    .busy(rx_busy), .running(rx_running), .finish(rx_finish), .word(rx_data)
  );

  assign flag_set = {rx_finish, tx_finish};
  assign flag_clr = {rx_done_clr, tx_done_clr};

  for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
    ssp_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(flag_set[f]), .clr(flag_clr[f]), .q(flag_q[f])
    );
  end

  assign tx_done   = flag_q[0];
  assign rx_done   = flag_q[1];
  assign sd_out    = tx_bit;
  assign sd_oe     = tx_sending;
  assign shift_clk = !((tx_sending || rx_running) && clk_low);
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_ready,
  input logic              sd_oe,
  input logic              sd_out,
  input logic              shift_clk,
  input logic              tx_done,
  input logic              rx_done,
  input logic              rx_done_clr,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_running,
  input logic              shift_stb
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe |-> sd_out);

  p_ready_in_last_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> shift_stb);

  p_oe_rises_after_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_oe) |-> $past(shift_stb));

  p_done_with_oe_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $fell(sd_oe));

  p_clock_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sd_oe || rx_running) |-> shift_clk);

  p_word_only_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(rx_done) |-> $stable(rx_data));

  p_no_take_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe || rx_running) |-> !tx_ready);

  p_flag_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_done_clr) |=> rx_done);

  p_half_duplex_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sd_oe && rx_running));
endmodule

bind ssp_serial_port ssp_port_chk #(.DATA_W(DATA_W)) u_port_chk (
  .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .sd_oe(sd_oe), .sd_out(sd_out),
  .shift_clk(shift_clk), .tx_done(tx_done), .rx_done(rx_done),
  .rx_done_clr(rx_done_clr), .rx_data(rx_data), .rx_running(rx_running),
  .shift_stb(shift_stb)
);

// File: tb/test_ssp_serial_port.sv
`timescale 1ns/1ps
module test_ssp_serial_port;
  localparam int W  = 8;
  localparam int SL = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_valid = 1'b0, rx_en = 1'b0, tx_done_clr = 1'b0, rx_done_clr = 1'b0;
  logic sd_in = 1'b1;
  logic [W-1:0] tx_data = '0;
  logic tx_ready, tx_done, rx_done, sd_out, sd_oe, shift_clk;
  logic [W-1:0] rx_data;

  always #4 clk = ~clk;

  ssp_serial_port #(.DATA_W(W)) i_ssp_serial_port (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_en(rx_en), .rx_data(rx_data), .tx_done(tx_done), .tx_done_clr(tx_done_clr),
    .rx_done(rx_done), .rx_done_clr(rx_done_clr), .sd_out(sd_out), .sd_oe(sd_oe),
    .sd_in(sd_in), .shift_clk(shift_clk)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, t_acc = 0;
  bit finished = 0;
  logic [W-1:0] rx_pat = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // behavioural reference: integer counters per direction
  int m_slot = 0, m_txc = -1, m_rxc = -1;
  bit m_rxp = 0, m_ti = 0, m_ri = 0, m_samp = 1;
  bit m_last, m_idle, m_acc_ev, m_go, m_tdone, m_rdone;
  logic [W-1:0] m_byte = '0, m_acc = '0, m_rxdata = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_slot = 0; m_txc = -1; m_rxc = -1; m_rxp = 0;
      m_ti = 0; m_ri = 0; m_samp = 1; m_rxdata = '0;
    end else begin
      m_last   = (m_slot == SL - 1);
      m_idle   = (m_txc < 0) && !m_rxp && (m_rxc < 0);
      m_acc_ev = tx_valid && m_idle && m_last;
      m_go     = m_last && rx_en && !m_ri && m_idle && !m_acc_ev;
      m_tdone  = 0;
      m_rdone  = 0;
      if (m_rxp) begin m_rxp = 0; m_rxc = 0; end
      if (m_rxc >= 0 && m_slot == 9) m_samp = sd_in;
      if (m_rxc >= 0 && m_last) begin
        m_acc[m_rxc] = m_samp;
        m_rxc++;
        if (m_rxc == W) begin m_rxdata = m_acc; m_rxc = -1; m_rdone = 1; end
      end
      if (m_last && m_txc >= 0) begin
        if (m_txc == W) begin m_txc = -1; m_tdone = 1; end
        else m_txc++;
      end
      if (m_acc_ev) begin m_txc = 0; m_byte = tx_data; end
      if (m_go) m_rxp = 1;
      m_ti = m_tdone | (m_ti & !tx_done_clr);
      m_ri = m_rdone | (m_ri & !rx_done_clr);
      m_slot = (m_slot + 1) % SL;
    end
  end

  // partner drives one bit per active receive cycle
  always @(negedge clk)
    sd_in <= (m_rxc >= 0 && m_rxc < W) ? rx_pat[m_rxc] : 1'b1;

  // per-clock comparison of every output
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_oe, e_do, e_run, e_sclk, e_rdy;
      e_oe   = (m_txc >= 1);
      e_do   = e_oe ? m_byte[m_txc-1] : 1'b1;
      e_run  = (m_rxc >= 0);
      e_sclk = !((e_oe || e_run) && m_slot >= 4 && m_slot <= 9);
      e_rdy  = (m_txc < 0) && !m_rxp && (m_rxc < 0) && (m_slot == SL - 1);
      chk(tx_ready === e_rdy, (m_txc >= 0) ? "R9" : ((m_rxp || e_run) ? "R11" : "R2"),
          longint'(tx_ready), longint'(e_rdy));
      chk(sd_oe === e_oe, "R3", longint'(sd_oe), longint'(e_oe));
      chk(sd_out === e_do, e_oe ? "R3" : "R1", longint'(sd_out), longint'(e_do));
      chk(shift_clk === e_sclk, e_run ? "R6" : "R5", longint'(shift_clk), longint'(e_sclk));
      chk(tx_done === m_ti, "R4", longint'(tx_done), longint'(m_ti));
      chk(rx_done === m_ri, "R8", longint'(rx_done), longint'(m_ri));
      chk(rx_data === m_rxdata, "R7", longint'(rx_data), longint'(m_rxdata));
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      finish_run();
    end
  end

  task automatic send_byte(input logic [W-1:0] d);
    tx_data  = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    t_acc    = cyc;
    tx_valid = 1'b0;
  endtask

  task automatic wait_tx_done();
    while (!tx_done) @(negedge clk);
  endtask

  task automatic wait_rx_done();
    while (!rx_done) @(negedge clk);
  endtask

  task automatic pulse_clear(input bit tx_side, input bit rx_side);
    tx_done_clr = tx_side; rx_done_clr = rx_side;
    @(negedge clk);
    tx_done_clr = 1'b0; rx_done_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: levels while reset is held
    chk(sd_oe == 1'b0,     "R1", longint'(sd_oe), 0);
    chk(sd_out == 1'b1,    "R1", longint'(sd_out), 1);
    chk(shift_clk == 1'b1, "R1", longint'(shift_clk), 1);
    chk(tx_done == 1'b0 && rx_done == 1'b0, "R1", longint'({tx_done, rx_done}), 0);
    chk(rx_data == '0,     "R1", longint'(rx_data), 0);
    chk(tx_ready == 1'b0,  "R1", longint'(tx_ready), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // transmit, with a write offered mid-transfer (R9)
    send_byte(8'hA5);
    repeat (20) @(negedge clk);
    tx_data = 8'h3C; tx_valid = 1'b1;
    for (int k = 0; k < 40; k++) begin
      chk(tx_ready == 1'b0, "R9", longint'(tx_ready), 0);
      @(negedge clk);
    end
    tx_valid = 1'b0;
    wait_tx_done();
    chk(cyc - t_acc == 108, "R4", longint'(cyc - t_acc), 108);
    pulse_clear(1'b1, 1'b0);
    chk(tx_done == 1'b0, "R10", longint'(tx_done), 0);

    send_byte(8'h80);
    wait_tx_done();
    repeat (30) @(negedge clk);
    chk(tx_done == 1'b1, "R10", longint'(tx_done), 1);
    pulse_clear(1'b1, 1'b0);

    // first reception
    rx_pat = 8'h3C;
    rx_en  = 1'b1;
    wait_rx_done();
    rx_en  = 1'b0;
    chk(rx_data == 8'h3C, "R7", longint'(rx_data), 8'h3C);

    // flag set blocks re-arm
    rx_en = 1'b1;
    for (int k = 0; k < 40; k++) begin
      chk(shift_clk == 1'b1 && rx_done == 1'b1, "R10", longint'({shift_clk, rx_done}), 3);
      @(negedge clk);
    end

    // clear that collides with completion: set wins
    rx_pat = 8'h81;
    pulse_clear(1'b0, 1'b1);
    while (!(m_rxc == W - 1 && m_slot == SL - 1)) @(negedge clk);
    rx_done_clr = 1'b1;
    @(negedge clk);
    rx_done_clr = 1'b0;
    chk(rx_done == 1'b1, "R10", longint'(rx_done), 1);
    chk(rx_data == 8'h81, "R7", longint'(rx_data), 8'h81);
    rx_en = 1'b0;

    // transmit offered during reception waits for it
    rx_pat = 8'h5A;
    rx_en  = 1'b1;
    pulse_clear(1'b0, 1'b1);
    repeat (30) @(negedge clk);
    send_byte(8'h77);
    chk(rx_done == 1'b1, "R11", longint'(rx_done), 1);
    chk(rx_data == 8'h5A, "R11", longint'(rx_data), 8'h5A);
    rx_en = 1'b0;
    wait_tx_done();
    pulse_clear(1'b1, 1'b1);

    // both directions ready at one slot: transmit wins
    rx_pat   = 8'hC6;
    rx_en    = 1'b1;
    send_byte(8'h1F);
    repeat (12) @(negedge clk);
    chk(sd_oe == 1'b1, "R11", longint'(sd_oe), 1);
    wait_tx_done();
    wait_rx_done();
    chk(rx_data == 8'hC6, "R11", longint'(rx_data), 8'hC6);
    chk(cyc - t_acc > 108, "R11", longint'(cyc - t_acc), 109);
    rx_en = 1'b0;
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule